// File: doc/BRIEF.md
# Two-Phase Bipolar Stepper Gate Sequencer

This block converts a step clock, a direction level, an enable level and a step-size select into switch enables for two H-bridges. Together the bridges drive the two windings of a bipolar stepper motor. Each winding is driven with one of three polarities: positive, which closes the Q1/Q4 diagonal; negative, which closes the Q2/Q3 diagonal; or off, which leaves all four switches open. Winding B runs a quarter cycle behind winding A.

The motor position is held as an index into an eight-entry excitation table. In half-step mode each step moves one table entry, and the table includes states in which one winding is unpowered. In full-step mode each step moves two entries, so only the states with both windings energised are used. The step clock and the reset release are resynchronised to the system clock. Each bridge has its own blanking stage. When that stage leaves an active polarity, the bridge is held fully off for a programmable number of cycles, and no switch pair can close against the other.

Top module: `bipolar_step_seq`

## Requirements
- R1: While `rst_n` is low, all eight gate outputs are 0. After release with `en` high, both bridges settle to positive drive, so `gate_a` = `gate_b` = 4'b1001. The gate bit order is bit0=Q1, bit1=Q2, bit2=Q3, bit3=Q4.
- R2: In full-step mode with `dir_fwd`=1, successive steps visit A+B+, A-B+, A-B-, A+B-, and then wrap. Positive polarity is 4'b1001 and negative polarity is 4'b0110.
- R3: With `dir_fwd`=0, steps visit the same states in the opposite order.
- R4: In half-step mode the cycle has eight states: A+B+, A0B+, A-B+, A-B0, A-B-, A0B-, A+B-, A+B0. An off winding (0) has all four gates low.
- R5: One cycle after `en` is sampled low, all eight gates are 0.
- R6: Steps that arrive while `en` is low are ignored. When `en` returns high, the drive resumes in the state that was held before the disable.
- R7: When a bridge leaves an active polarity, it stays fully off for at least DEAD_CYCLES+1 cycles before any switch pair closes again.
- R8: Q1 and Q2 of a bridge are never both on, and Q3 and Q4 are never both on. The only gate patterns that appear are 4'b0000, 4'b1001 and 4'b0110.
- R9: If the first full-mode step is taken from a half-step-only state, the drive moves to the nearest both-windings state in the direction of travel.
- R10: Applying reset in the middle of a run returns the drive to the home state A+B+.
- R11: Each rising edge of `step_in` produces exactly one step, no matter how long `step_in` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| step_in | input | 1 | Step clock; each rising edge requests one step |
| dir_fwd | input | 1 | 1 advances through the table, 0 goes backwards |
| en | input | 1 | 1 drives the bridges, 0 opens all switches and freezes the position |
| half_mode | input | 1 | 1 selects half steps, 0 selects full steps |
| gate_a | output | 4 | Winding A bridge switch enables, bit0..bit3 = Q1..Q4 |
| gate_b | output | 4 | Winding B bridge switch enables, bit0..bit3 = Q1..Q4 |

## Verification
The bench builds the block with DEAD_CYCLES=3 and SYNC_STAGES=2. With those values a blanking window lasts four cycles, long enough to measure. The bench times the off-run of each bridge at every full-step polarity reversal and compares it against the bound. Step pulses are spaced far enough apart that every state settles, so each step's gate pattern can be compared with the excitation table. The spacing also covers mode switches from odd half-step positions and steps that arrive while the drive is disabled.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

  localparam int IDX_W         = 3;
  localparam int NUM_PHASES    = 2;
  localparam int SW_PER_BRIDGE = 4;

  typedef enum logic [1:0] {
    POL_OFF = 2'd0,
    POL_POS = 2'd1,
    POL_NEG = 2'd2
  } pol_e;

  // Winding A polarity over the eight-entry excitation table
  function automatic pol_e pol_of_a(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0, 3'd6, 3'd7: pol_of_a = POL_POS;
      3'd2, 3'd3, 3'd4: pol_of_a = POL_NEG;
      default:          pol_of_a = POL_OFF;
    endcase
  endfunction

  // Winding B lags A by a quarter of the cycle
  function automatic pol_e pol_of_b(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0, 3'd1, 3'd2: pol_of_b = POL_POS;
      3'd4, 3'd5, 3'd6: pol_of_b = POL_NEG;
      default:          pol_of_b = POL_OFF;
    endcase
  endfunction

  // bit0=Q1, bit1=Q2, bit2=Q3, bit3=Q4
  function automatic logic [SW_PER_BRIDGE-1:0] sw_of_pol(input pol_e p);
    case (p)
      POL_POS: sw_of_pol = 4'b1001;
      POL_NEG: sw_of_pol = 4'b0110;
      default: sw_of_pol = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/step_rst_sync.sv
module step_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/step_edge_sync.sv
module step_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/step_index.sv
module step_index
  import step_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_pulse,
  input  logic             en,
  input  logic             dir_fwd,
  input  logic             half_mode,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             adv;

  assign adv = step_pulse & en;

  always_comb begin
    idx_n = idx_q;
    if (adv) begin
      if (half_mode) begin
        idx_n = dir_fwd ? idx_q + 3'd1 : idx_q - 3'd1;
      end else if (dir_fwd) begin
        idx_n = {idx_q[2:1] + 2'd1, 1'b0};
      end else if (idx_q[0]) begin
        idx_n = {idx_q[2:1], 1'b0};
      end else begin
        idx_n = {idx_q[2:1] - 2'd1, 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (adv) idx_q <= idx_n;
  end

  assign idx = idx_q;
endmodule

// File: rtl/step_bridge_drv.sv
module step_bridge_drv
  import step_seq_pkg::*;
#(
  parameter int DEAD_CYCLES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  pol_e                     req,
  output logic [SW_PER_BRIDGE-1:0] sw
);
  localparam int CNT_W = (DEAD_CYCLES < 1) ? 1 : $clog2(DEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYCLES);

  pol_e             pol_q, pol_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    pol_n = pol_q;
    cnt_n = cnt_q;
    if (!en) begin
      pol_n = POL_OFF;
      cnt_n = CNT_LOAD;
    end else if (pol_q != POL_OFF) begin
      if (req != pol_q) begin
        pol_n = POL_OFF;
        cnt_n = CNT_LOAD;
      end
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end else begin
      pol_n = req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= POL_OFF;
      cnt_q <= CNT_LOAD;
    end else begin
      pol_q <= pol_n;
      cnt_q <= cnt_n;
    end
  end

  assign sw = sw_of_pol(pol_q);
endmodule

// File: rtl/bipolar_step_seq.sv
module bipolar_step_seq
  import step_seq_pkg::*;
#(
  parameter int DEAD_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_in,
  input  logic       dir_fwd,
  input  logic       en,
  input  logic       half_mode,
  output logic [3:0] gate_a,
  output logic [3:0] gate_b
);
  logic             rst_core_n;
  logic             step_pulse;
  logic [IDX_W-1:0] idx;
  pol_e             req [NUM_PHASES];
  logic [NUM_PHASES-1:0][SW_PER_BRIDGE-1:0] sw;

  step_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  step_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_core_n), .din(step_in), .rise(step_pulse)
  );

  step_index u_idx (
    .clk(clk), .rst_n(rst_core_n), .step_pulse(step_pulse), .en(en),
    .dir_fwd(dir_fwd), .half_mode(half_mode), .idx(idx)
  );

  always_comb begin
    req[0] = pol_of_a(idx);
    req[1] = pol_of_b(idx);
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_bridge
    step_bridge_drv #(.DEAD_CYCLES(DEAD_CYCLES)) u_drv (
      .clk(clk), .rst_n(rst_core_n), .en(en), .req(req[g]), .sw(sw[g])
    );
  end

  assign gate_a = sw[0];
  assign gate_b = sw[1];
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk #(
  parameter int DEAD_CYCLES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [3:0] gate_a,
  input logic [3:0] gate_b
);
  localparam int RUN_W = $clog2(DEAD_CYCLES + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DEAD_CYCLES + 1);

  logic [RUN_W-1:0] off_a_q, off_b_q;
  logic [3:0]       last_a_q, last_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_a_q  <= '0;
      off_b_q  <= '0;
      last_a_q <= 4'b0000;
      last_b_q <= 4'b0000;
    end else begin
      if (gate_a == 4'b0000) begin
        if (off_a_q != RUN_MAX) off_a_q <= off_a_q + 1'b1;
      end else begin
        off_a_q  <= '0;
        last_a_q <= gate_a;
      end
      if (gate_b == 4'b0000) begin
        if (off_b_q != RUN_MAX) off_b_q <= off_b_q + 1'b1;
      end else begin
        off_b_q  <= '0;
        last_b_q <= gate_b;
      end
    end
  end

  p_leg_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a[0] & gate_a[1]) && !(gate_a[2] & gate_a[3]) &&
    !(gate_b[0] & gate_b[1]) && !(gate_b[2] & gate_b[3]));

  p_pattern_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a == 4'b0000 || gate_a == 4'b1001 || gate_a == 4'b0110) &&
    (gate_b == 4'b0000 || gate_b == 4'b1001 || gate_b == 4'b0110));

  p_disable_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate_a == 4'b0000 && gate_b == 4'b0000));

  p_dead_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a != 4'b0000 && last_a_q != 4'b0000 && gate_a != last_a_q)
      |-> off_a_q >= RUN_MAX);

  p_dead_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_b != 4'b0000 && last_b_q != 4'b0000 && gate_b != last_b_q)
      |-> off_b_q >= RUN_MAX);

  p_no_direct_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a == 4'b0110) |-> ($past(gate_a) != 4'b1001));
endmodule

bind bipolar_step_seq step_seq_chk #(.DEAD_CYCLES(DEAD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .gate_a(gate_a), .gate_b(gate_b)
);

// File: tb/bipolar_step_seq_tb.sv
`timescale 1ns/1ps
module bipolar_step_seq_tb;
  localparam int DEAD = 3;

  logic       clk = 1'b0;
  logic       rst_n, step_in, dir_fwd, en, half_mode;
  logic [3:0] gate_a, gate_b;

  int total = 0;
  int bad   = 0;
  logic [2:0] m_idx;
  bit done = 0;

  // monitor state for R7/R8
  int off_a = 0, off_b = 0;
  logic [3:0] last_a = 4'b0, last_b = 4'b0;
  int rev_min = 1000;
  int rev_cnt = 0;
  int leg_bad = 0;

  always #2.5 clk = ~clk;

  bipolar_step_seq #(.DEAD_CYCLES(DEAD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_fwd(dir_fwd),
    .en(en), .half_mode(half_mode), .gate_a(gate_a), .gate_b(gate_b)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      off_a = 0; off_b = 0; last_a = 4'b0; last_b = 4'b0;
    end else begin
      if ((gate_a[0] & gate_a[1]) | (gate_a[2] & gate_a[3]) |
          (gate_b[0] & gate_b[1]) | (gate_b[2] & gate_b[3])) leg_bad++;
      if (gate_a == 4'b0) off_a++;
      else begin
        if (last_a != 4'b0 && gate_a != last_a) begin
          rev_cnt++;
          if (off_a < rev_min) rev_min = off_a;
        end
        last_a = gate_a; off_a = 0;
      end
      if (gate_b == 4'b0) off_b++;
      else begin
        if (last_b != 4'b0 && gate_b != last_b) begin
          rev_cnt++;
          if (off_b < rev_min) rev_min = off_b;
        end
        last_b = gate_b; off_b = 0;
      end
    end
  end

  function automatic logic [3:0] exp_a(input logic [2:0] i);
    case (i)
      3'd0, 3'd6, 3'd7: exp_a = 4'b1001;
      3'd2, 3'd3, 3'd4: exp_a = 4'b0110;
      default:          exp_a = 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] exp_b(input logic [2:0] i);
    case (i)
      3'd0, 3'd1, 3'd2: exp_b = 4'b1001;
      3'd4, 3'd5, 3'd6: exp_b = 4'b0110;
      default:          exp_b = 4'b0000;
    endcase
  endfunction

  function automatic logic [2:0] model_step(input logic [2:0] i, input logic fwd,
                                            input logic half);
    if (half)     model_step = fwd ? i + 3'd1 : i - 3'd1;
    else if (fwd) model_step = {i[2:1] + 2'd1, 1'b0};
    else if (i[0]) model_step = {i[2:1], 1'b0};
    else          model_step = {i[2:1] - 2'd1, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, gate_a, exp_a(m_idx));
    chk(req, gate_b, exp_b(m_idx));
  endtask

  task automatic pulse(input int high_cycles);
    step_in = 1'b1;
    repeat (high_cycles) @(negedge clk);
    step_in = 1'b0;
    repeat (20) @(negedge clk);
    if (en) m_idx = model_step(m_idx, dir_fwd, half_mode);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", gate_a, 4'b0000);
    chk("R1", gate_b, 4'b0000);
    rst_n = 1'b1;
    m_idx = 3'd0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset_home();
    do_reset();
    chk("R1", gate_a, 4'b1001);
    chk("R1", gate_b, 4'b1001);
  endtask

  task automatic t_full_fwd();
    half_mode = 1'b0; dir_fwd = 1'b1;
    for (int k = 0; k < 5; k++) begin
      pulse(4);
      chk_state("R2");
    end
  endtask

  task automatic t_full_rev();
    half_mode = 1'b0; dir_fwd = 1'b0;
    for (int k = 0; k < 5; k++) begin
      pulse(4);
      chk_state("R3");
    end
  endtask

  task automatic t_half();
    half_mode = 1'b1; dir_fwd = 1'b1;
    for (int k = 0; k < 9; k++) begin
      pulse(3);
      chk_state("R4");
    end
    dir_fwd = 1'b0;
    for (int k = 0; k < 3; k++) begin
      pulse(3);
      chk_state("R4");
    end
  endtask

  task automatic t_disable();
    logic [2:0] held;
    half_mode = 1'b1; dir_fwd = 1'b1;
    pulse(3);
    held = m_idx;
    en = 1'b0;
    @(negedge clk);
    chk("R5", gate_a, 4'b0000);
    chk("R5", gate_b, 4'b0000);
    pulse(3);
    pulse(3);
    chk("R5", gate_a | gate_b, 4'b0000);
    en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R6", {1'b0, m_idx}, {1'b0, held});
    chk_state("R6");
  endtask

  task automatic t_mode_switch();
    // make the position odd, then take a full step each way
    half_mode = 1'b1; dir_fwd = 1'b1;
    while (m_idx[0] == 1'b0) pulse(3);
    half_mode = 1'b0; dir_fwd = 1'b1;
    pulse(3);
    chk_state("R9");
    half_mode = 1'b1;
    pulse(3);
    half_mode = 1'b0; dir_fwd = 1'b0;
    pulse(3);
    chk_state("R9");
  endtask

  task automatic t_long_pulse();
    half_mode = 1'b1; dir_fwd = 1'b1;
    pulse(40);
    chk_state("R11");
  endtask

  task automatic t_mid_reset();
    half_mode = 1'b0; dir_fwd = 1'b1;
    pulse(3);
    pulse(3);
    do_reset();
    chk("R10", gate_a, 4'b1001);
    chk("R10", gate_b, 4'b1001);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_in = 1'b0; dir_fwd = 1'b1; en = 1'b1; half_mode = 1'b0;
    m_idx = 3'd0;
    t_reset_home();
    t_full_fwd();
    t_full_rev();
    t_half();
    t_disable();
    t_mode_switch();
    t_long_pulse();
    t_mid_reset();
    // R7: every observed reversal had a long enough off-run
    total++;
    if (rev_cnt == 0 || rev_min < DEAD + 1) begin
      bad++;
      $display("FAIL R7: actual=min_off %0d reversals %0d expected=min_off>=%0d",
               rev_min, rev_cnt, DEAD + 1);
    end
    // R8: leg exclusivity held on every sampled cycle
    total++;
    if (leg_bad != 0) begin
      bad++;
      $display("FAIL R8: actual=%0d overlaps expected=0", leg_bad);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule